// File: doc/BRIEF.md
# Saturating Errored Block Counter

This block keeps a tally of errored multiframes seen by a T1 receive framer and presents it as a 16-bit value split into two bytes for a register read path. The framer supplies one boundary strobe per multiframe, and the CRC and frame-alignment error flags for the multiframe that is closing arrive in the same cycle as that strobe. A format input selects ESF or the 4/12/72-frame superframe. A sync input gates normal counting. An alarm-simulation enable forces counts in a way that depends on the format.

Two capture schemes share one buffer. With the latch-mode input low, software sets a snapshot bit. Its rising edge freezes the buffer and restarts the live counter, and a read of the high byte clears the bit so that the buffer follows the counter again. With the latch-mode input high, each one-second tick copies the live count into the buffer, restarts the counter and raises a one-cycle pulse for an interrupt controller.

The capture controller is a three-state machine.
- TRACK: the buffer follows the counter. It moves to FROZEN on a snapshot edge and to AUTO when latch mode is high.
- FROZEN: the buffer holds its value. It moves to TRACK on a high-byte read and to AUTO when latch mode is high.
- AUTO: the buffer loads on each tick. It moves to TRACK when latch mode goes low.

A second machine handles alarm simulation in the superframe formats. It has the states IDLE, ARMED and SPENT. It moves from IDLE to ARMED while simulation is enabled, from ARMED to SPENT on a superframe-format boundary, and from ARMED or SPENT back to IDLE when simulation is disabled.

Top module: `errblk_counter`

## Requirements
- R1: After reset the buffer reads 0x0000, the snapshot bit reads 0, the second pulse is low and the live counter is 0.
- R2: In ESF format (fmt_esf=1), when in sync and without alarm simulation, a boundary strobe whose crc_err or fa_err is high adds exactly one to the counter. A strobe with neither flag high adds nothing.
- R3: In superframe format (fmt_esf=0) only fa_err on a boundary strobe counts. A strobe with only crc_err high adds nothing.
- R4: While in_sync is 0 and alarm simulation is off, no error is counted.
- R5: The counter stops at 0xFFFF and never wraps.
- R6: With alarm simulation on in ESF format, every boundary strobe adds one, whatever the error flags and the sync state.
- R7: With alarm simulation on in superframe format, exactly one count is added. It is added on the first boundary strobe that arrives at least one cycle after the enable goes high. Nothing more is added until the enable drops and rises again.
- R8: In TRACK the buffer equals the live counter value of the previous cycle.
- R9: In TRACK, a snapshot_set pulse while the snapshot bit is 0 sets the bit and loads the buffer with the current count. The counter restarts, and the buffer then holds its value in FROZEN.
- R10: A rd_hi pulse clears the snapshot bit. From FROZEN the machine returns to TRACK and the buffer follows the counter again.
- R11: In AUTO, a sec_tick copies the count into the buffer and restarts the counter. sec_pulse is high for exactly the following cycle, and the buffer does not change between ticks.
- R12: If a counted event falls in the same cycle as a snapshot restart or a tick restart, the counter restarts at 1.
- R13: A change of latch_mode takes effect through a state change one cycle later. Snapshot edges in AUTO do not touch the buffer or the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_esf | input | 1 | 1 = ESF, 0 = 4/12/72-frame superframe |
| in_sync | input | 1 | 1 = receiver in frame |
| alm_sim | input | 1 | Alarm simulation enable |
| mf_strobe | input | 1 | Multiframe boundary strobe |
| crc_err | input | 1 | CRC error for the closing multiframe |
| fa_err | input | 1 | Frame-alignment error for the closing multiframe |
| latch_mode | input | 1 | 1 = per-second latch, 0 = software snapshot |
| sec_tick | input | 1 | One-second tick |
| snap_set | input | 1 | Write pulse that sets the snapshot bit |
| rd_hi | input | 1 | Read strobe of the high buffer byte |
| buf_lo | output | 8 | Buffer bits 7..0 |
| buf_hi | output | 8 | Buffer bits 15..8 |
| snap_bit | output | 1 | Snapshot bit |
| sec_pulse | output | 1 | One-cycle pulse after each per-second latch |

## Verification
The hardest state to reach from the ports is saturation. It needs 65,535 counted multiframes before the stop at 0xFFFF can be observed. The bench reaches it by turning on ESF alarm simulation and holding the boundary strobe high on every clock, so that each cycle counts. The restart-at-one collisions are reached by lining up a snapshot pulse or a tick with an error strobe in a single cycle. A behavioural model, compared on every clock, covers long random stretches between the directed phases.

// File: rtl/errblk_pkg.sv
package errblk_pkg;
    typedef enum logic [1:0] {CAP_TRACK, CAP_FROZEN, CAP_AUTO} cap_state_e;
    typedef enum logic [1:0] {SIM_IDLE, SIM_ARMED, SIM_SPENT} sim_state_e;
endpackage

// File: rtl/errblk_qualify.sv
module errblk_qualify
    import errblk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fmt_esf,
    input  logic in_sync,
    input  logic alm_sim,
    input  logic mf_strobe,
    input  logic crc_err,
    input  logic fa_err,
    output logic inc_o
);
    sim_state_e sim_q, sim_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sim_q <= SIM_IDLE;
        else        sim_q <= sim_d;
    end

    always_comb begin
        sim_d = sim_q;
        unique case (sim_q)
            SIM_IDLE:  if (alm_sim) sim_d = SIM_ARMED;
            SIM_ARMED: begin
                if (!alm_sim)                    sim_d = SIM_IDLE;
                else if (mf_strobe && !fmt_esf)  sim_d = SIM_SPENT;
            end
            SIM_SPENT: if (!alm_sim) sim_d = SIM_IDLE;
            default:   sim_d = SIM_IDLE;
        endcase
    end

    always_comb begin
        if (alm_sim)
            inc_o = fmt_esf ? mf_strobe : (mf_strobe && sim_q == SIM_ARMED);
        else
            inc_o = mf_strobe && in_sync && (fa_err || (fmt_esf && crc_err));
    end

    // R7
    sim_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sim_q == SIM_SPENT && alm_sim && !fmt_esf) |-> !inc_o);

    // R7
    sim_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sim_q == SIM_ARMED && alm_sim && !fmt_esf && mf_strobe) |=> sim_q == SIM_SPENT);
endmodule

// File: rtl/errblk_count.sv
module errblk_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= inc_i ? CNT_ONE : '0;
        else if (inc_i && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + CNT_ONE;
    end

    assign cnt_o = cnt_q;

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);

    // R12
    restart_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && inc_i) |=> cnt_q == CNT_ONE);

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE));
endmodule

// File: rtl/errblk_counter.sv
module errblk_counter
    import errblk_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_esf,
    input  logic              in_sync,
    input  logic              alm_sim,
    input  logic              mf_strobe,
    input  logic              crc_err,
    input  logic              fa_err,
    input  logic              latch_mode,
    input  logic              sec_tick,
    input  logic              snap_set,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] buf_lo,
    output logic [BYTE_W-1:0] buf_hi,
    output logic              snap_bit,
    output logic              sec_pulse
);
    localparam int CNT_W = 2 * BYTE_W;

    cap_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_w, buf_q;
    logic             inc_w, clr_w, snap_edge, snap_q, pulse_q;

    errblk_qualify u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_esf   (fmt_esf),
        .in_sync   (in_sync),
        .alm_sim   (alm_sim),
        .mf_strobe (mf_strobe),
        .crc_err   (crc_err),
        .fa_err    (fa_err),
        .inc_o     (inc_w)
    );

    assign snap_edge = snap_set && !snap_q;
    assign clr_w     = (state_q == CAP_TRACK && snap_edge) ||
                       (state_q == CAP_AUTO  && sec_tick);

    errblk_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (inc_w),
        .clr_i (clr_w),
        .cnt_o (cnt_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_TRACK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_TRACK: begin
                if (latch_mode)     state_d = CAP_AUTO;
                else if (snap_edge) state_d = CAP_FROZEN;
            end
            CAP_FROZEN: begin
                if (latch_mode)     state_d = CAP_AUTO;
                else if (rd_hi)     state_d = CAP_TRACK;
            end
            CAP_AUTO:   if (!latch_mode) state_d = CAP_TRACK;
            default:    state_d = CAP_TRACK;
        endcase
    end

    // outputs: buffer, snapshot bit, second pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            snap_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            unique case (state_q)
                CAP_TRACK:  buf_q <= cnt_w;
                CAP_FROZEN: buf_q <= buf_q;
                CAP_AUTO:   if (sec_tick) buf_q <= cnt_w;
                default:    buf_q <= buf_q;
            endcase
            if (snap_edge)  snap_q <= 1'b1;
            else if (rd_hi) snap_q <= 1'b0;
            pulse_q <= (state_q == CAP_AUTO) && sec_tick;
        end
    end

    assign buf_lo    = buf_q[BYTE_W-1:0];
    assign buf_hi    = buf_q[CNT_W-1:BYTE_W];
    assign snap_bit  = snap_q;
    assign sec_pulse = pulse_q;

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_FROZEN) |=> $stable(buf_q));

    // R11
    sec_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_AUTO && sec_tick) |=> (sec_pulse && cnt_w <= 1));

    // R4
    nosync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sync && !alm_sim && !clr_w) |=> $stable(cnt_w));

    // R10
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_FROZEN && rd_hi && !latch_mode) |=> (state_q == CAP_TRACK && !snap_q));

    // R13
    auto_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_AUTO && !sec_tick) |=> $stable(buf_q));
endmodule

// File: tb/errblk_counter_test.sv
module errblk_counter_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fmt_esf = 1'b1, in_sync = 1'b1, alm_sim = 1'b0, mf_strobe = 1'b0;
    logic crc_err = 1'b0, fa_err = 1'b0, latch_mode = 1'b0, sec_tick = 1'b0;
    logic snap_set = 1'b0, rd_hi = 1'b0;
    logic [7:0] buf_lo, buf_hi;
    logic snap_bit, sec_pulse;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    int m_cnt = 0, m_buf = 0, m_state = 0, m_sim = 0;
    bit m_snap = 0, m_pulse = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errblk_counter uut (
        .clk(clk), .rst_n(rst_n), .fmt_esf(fmt_esf), .in_sync(in_sync),
        .alm_sim(alm_sim), .mf_strobe(mf_strobe), .crc_err(crc_err), .fa_err(fa_err),
        .latch_mode(latch_mode), .sec_tick(sec_tick), .snap_set(snap_set), .rd_hi(rd_hi),
        .buf_lo(buf_lo), .buf_hi(buf_hi), .snap_bit(snap_bit), .sec_pulse(sec_pulse)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_buf = 0; m_state = 0; m_sim = 0; m_snap = 0; m_pulse = 0;
        end else begin
            bit inc, edge_s, clr;
            int n_state, n_sim;
            if (alm_sim) inc = fmt_esf ? mf_strobe : (mf_strobe && m_sim == 1);
            else         inc = mf_strobe && in_sync && (fa_err || (fmt_esf && crc_err));
            edge_s = snap_set && !m_snap;
            clr = (m_state == 0 && edge_s) || (m_state == 2 && sec_tick);
            if (m_state == 0 || (m_state == 2 && sec_tick)) m_buf = m_cnt;
            m_pulse = (m_state == 2) && sec_tick;
            if (clr)                         m_cnt = inc ? 1 : 0;
            else if (inc && m_cnt < 65535)   m_cnt = m_cnt + 1;
            n_state = m_state;
            if (m_state == 0)      n_state = latch_mode ? 2 : (edge_s ? 1 : 0);
            else if (m_state == 1) n_state = latch_mode ? 2 : (rd_hi ? 0 : 1);
            else                   n_state = latch_mode ? 2 : 0;
            n_sim = m_sim;
            if (!alm_sim)                                n_sim = 0;
            else if (m_sim == 0)                         n_sim = 1;
            else if (m_sim == 1 && mf_strobe && !fmt_esf) n_sim = 2;
            if (edge_s)     m_snap = 1;
            else if (rd_hi) m_snap = 0;
            m_state = n_state;
            m_sim = n_sim;
        end
    end

    // every-clock comparison, requirement tag from the current phase
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if ({buf_hi, buf_lo} !== m_buf[15:0] || snap_bit !== m_snap || sec_pulse !== m_pulse) begin
                fails++;
                $display("FAIL %s: buf=%h snap=%b pulse=%b expected buf=%h snap=%b pulse=%b",
                         cur_req, {buf_hi, buf_lo}, snap_bit, sec_pulse, m_buf[15:0], m_snap, m_pulse);
            end
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mf(bit c, bit f);
        crc_err = c; fa_err = f; mf_strobe = 1'b1;
        cyc();
        crc_err = 1'b0; fa_err = 1'b0; mf_strobe = 1'b0;
        cyc();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(2);
        cur_req = "R1";
        chk("R1", {buf_hi, buf_lo}, 16'h0000);
        chk("R1", {15'd0, snap_bit}, 16'h0000);
        chk("R1", {15'd0, sec_pulse}, 16'h0000);

        cur_req = "R2";
        mf(1, 0); mf(0, 1); mf(1, 1); mf(0, 0);
        cyc();
        chk("R2", {buf_hi, buf_lo}, 16'd3);

        cur_req = "R3";
        fmt_esf = 1'b0;
        mf(1, 0); mf(0, 1);
        cyc();
        chk("R3", {buf_hi, buf_lo}, 16'd4);

        cur_req = "R4";
        in_sync = 1'b0;
        mf(1, 1); mf(0, 1);
        cyc();
        chk("R4", {buf_hi, buf_lo}, 16'd4);
        in_sync = 1'b1;

        cur_req = "R9";
        snap_set = 1'b1; cyc(); snap_set = 1'b0;
        mf(0, 1); mf(0, 1);
        cyc(2);
        chk("R9", {buf_hi, buf_lo}, 16'd4);
        chk("R9", {15'd0, snap_bit}, 16'd1);

        cur_req = "R10";
        rd_hi = 1'b1; cyc(); rd_hi = 1'b0;
        cyc(2);
        chk("R10", {buf_hi, buf_lo}, 16'd2);
        chk("R10", {15'd0, snap_bit}, 16'd0);

        cur_req = "R12";
        snap_set = 1'b1; mf_strobe = 1'b1; fa_err = 1'b1;
        cyc();
        snap_set = 1'b0; mf_strobe = 1'b0; fa_err = 1'b0;
        cyc();
        chk("R12", {buf_hi, buf_lo}, 16'd2);
        rd_hi = 1'b1; cyc(); rd_hi = 1'b0;
        cyc(2);
        chk("R12", {buf_hi, buf_lo}, 16'd1);

        cur_req = "R6";
        fmt_esf = 1'b1; in_sync = 1'b0; alm_sim = 1'b1;
        mf(0, 0); mf(0, 0); mf(0, 0);
        cyc();
        chk("R6", {buf_hi, buf_lo}, 16'd4);
        alm_sim = 1'b0; cyc();

        cur_req = "R7";
        fmt_esf = 1'b0;
        alm_sim = 1'b1; mf_strobe = 1'b1; cyc(); mf_strobe = 1'b0; cyc();
        mf(0, 0); mf(0, 1); mf(0, 0);
        cyc();
        chk("R7", {buf_hi, buf_lo}, 16'd5);
        alm_sim = 1'b0; cyc(2);
        alm_sim = 1'b1; cyc();
        mf(0, 0); mf(0, 0);
        cyc();
        chk("R7", {buf_hi, buf_lo}, 16'd6);
        alm_sim = 1'b0; in_sync = 1'b1; cyc();

        cur_req = "R13";
        latch_mode = 1'b1; cyc(2);
        mf(0, 1); mf(0, 1); mf(0, 1);
        snap_set = 1'b1; cyc(); snap_set = 1'b0; cyc();
        chk("R13", {buf_hi, buf_lo}, 16'd6);

        cur_req = "R11";
        sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
        chk("R11", {15'd0, sec_pulse}, 16'd1);
        chk("R11", {buf_hi, buf_lo}, 16'd9);
        cyc();
        chk("R11", {15'd0, sec_pulse}, 16'd0);
        mf(0, 1);
        chk("R11", {buf_hi, buf_lo}, 16'd9);

        cur_req = "R12";
        sec_tick = 1'b1; mf_strobe = 1'b1; fa_err = 1'b1;
        cyc();
        sec_tick = 1'b0; mf_strobe = 1'b0; fa_err = 1'b0;
        chk("R12", {buf_hi, buf_lo}, 16'd1);
        cyc(3);
        sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
        chk("R12", {buf_hi, buf_lo}, 16'd1);

        cur_req = "R5";
        latch_mode = 1'b0; rd_hi = 1'b1; cyc(); rd_hi = 1'b0; cyc();
        fmt_esf = 1'b1; alm_sim = 1'b1; mf_strobe = 1'b1;
        cyc(65540);
        mf_strobe = 1'b0; alm_sim = 1'b0;
        cyc(3);
        chk("R5", {buf_hi, buf_lo}, 16'hFFFF);
        mf(1, 1);
        cyc();
        chk("R5", {buf_hi, buf_lo}, 16'hFFFF);

        cur_req = "R8";
        rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
        for (int i = 0; i < 3000; i++) begin
            fmt_esf    = ($urandom_range(0, 7) != 0);
            in_sync    = ($urandom_range(0, 5) != 0);
            alm_sim    = ($urandom_range(0, 9) == 0);
            mf_strobe  = ($urandom_range(0, 2) == 0);
            crc_err    = $urandom_range(0, 1);
            fa_err     = ($urandom_range(0, 3) == 0);
            sec_tick   = ($urandom_range(0, 40) == 0);
            snap_set   = ($urandom_range(0, 30) == 0);
            rd_hi      = ($urandom_range(0, 25) == 0);
            if ($urandom_range(0, 200) == 0) latch_mode = ~latch_mode;
            cyc();
        end
        mf_strobe = 1'b0; sec_tick = 1'b0; snap_set = 1'b0; rd_hi = 1'b0;
        cyc(2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule